// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates a 32-bit effective address through a small set of large, variable-size mappings. Each mapping covers a region whose size is set by a mask. There are two separate banks of eight mappings: one for instruction fetches and one for data accesses. A lookup request carries the effective address, a bank select, a privilege flag and a segment identifier. One clock edge later the block returns one of two outcomes. On a hit it gives the translated physical address, the read, write and execute permissions, and a virtual page number. On a miss it raises a flag and drives all of those outputs to zero.

Software or a configuration sequencer loads the mappings through a word-wide write port. Each write selects a bank, an entry index and a field. An entry is used only when its valid bit for the current privilege level is set. It must also permit both reading and writing: read-only and no-access entries are passed over as if they were absent. When several entries qualify, the lowest-numbered one supplies the result. The block has no page-table walk, no segment storage and no translation cache.

Top module: `bat_matcher`

## Requirements
- R1: `req_side` selects the bank searched: 0 for the instruction bank, 1 for the data bank. The write port uses the same encoding on `wr_side`. An entry in one bank never affects a lookup in the other.
- R2: When `req_user` is 1, an entry is considered only if its user-valid bit is set. When `req_user` is 0, only its supervisor-valid bit counts.
- R3: An entry's address matches when (`req_ea` AND mask) equals its tag.
- R4: On a hit, `res_paddr` equals the entry's base ORed with (`req_ea` AND NOT mask).
- R5: The protection code sets what an entry allows: 0 means no access, 1 means read only, 2 or 3 means read and write. An entry whose code is below 2 is skipped even when it matches, and later entries are still searched. On a hit, `res_read`, `res_write` and `res_exec` are all 1.
- R6: When more than one entry qualifies, the lowest-numbered entry supplies the result.
- R7: On a hit, `res_vpage` equals {`req_seg`, `req_ea[27:12]`}.
- R8: When no entry qualifies, `res_miss` is 1, `res_hit` is 0, and `res_paddr`, `res_vpage` and the three permission outputs are 0.
- R9: A request with `req_valid` at a rising edge produces its result, and a one-cycle `res_valid`, at that same edge. Without a request, `res_valid` is 0 and the other outputs hold their values.
- R10: A write with `wr_en` high loads `wr_data` into one field of entry `wr_idx`. `wr_field` selects the field: 0 is the tag, 1 is the mask, 2 is the base, 3 is control. In the control field, bit 0 is supervisor-valid, bit 1 is user-valid and bits 3:2 are the protection code. A lookup in the next cycle sees the written value.
- R11: A synchronous reset (`rst_n` low) clears every entry field and every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | Bank written: 0 instruction, 1 data |
| wr_idx | input | 3 | Entry index written |
| wr_field | input | 2 | Field selector: tag, mask, base, control |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Lookup request |
| req_side | input | 1 | Bank searched: 0 instruction, 1 data |
| req_user | input | 1 | 1 for user privilege, 0 for supervisor |
| req_ea | input | 32 | Effective address |
| req_seg | input | 24 | Segment identifier for the virtual page |
| res_valid | output | 1 | Result strobe, one cycle per request |
| res_hit | output | 1 | Translation found |
| res_miss | output | 1 | No qualifying entry |
| res_paddr | output | 32 | Physical address |
| res_read | output | 1 | Read permitted |
| res_write | output | 1 | Write permitted |
| res_exec | output | 1 | Execute permitted |
| res_vpage | output | 40 | Virtual page number |

## Verification
The bench loads overlapping regions so that a matching read-only entry sits in front of a writable one. A design that stopped the search at the first address match would then miss or return the wrong base. The bench also overlaps a large region with a small one at a higher index. A design with the priority reversed would return the small region's base. Supervisor-only and user-only entries share one tag, so a design that swaps or ignores the valid bits returns the other region. An address one byte past a masked region and a no-access entry both check that a miss zeroes every output instead of leaving stale data. Reset is applied again after the entries are loaded; a design that does not clear them would still report a hit.

// File: rtl/bat_pkg.sv
// Shared types for the block address translation matcher.
// Assumes a 32-bit effective and physical address space.
package bat_pkg;
    parameter int ADDR_W      = 32;
    parameter int PROT_W      = 2;
    // lowest protection code that grants write access
    parameter int PROT_RW_MIN = 2;

    typedef enum logic [1:0] {
        FLD_TAG  = 2'd0,
        FLD_MASK = 2'd1,
        FLD_BASE = 2'd2,
        FLD_CTRL = 2'd3
    } bat_field_e;

    typedef struct packed {
        logic [ADDR_W-1:0] tag;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] base;
        logic              sup_ok;
        logic              usr_ok;
        logic [PROT_W-1:0] prot;
    } bat_entry_t;
endpackage

// File: rtl/bat_entry_bank.sv
// One bank of translation entries with a field-wise write port.
// Assumes wr_idx is below N_ENT; writes to other indices are ignored.
module bat_entry_bank
    import bat_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  bat_field_e              wr_field,
    input  logic [ADDR_W-1:0]       wr_data,
    output bat_entry_t [N_ENT-1:0]  ents
);
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        // Load the selected field of this entry, clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ents[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                case (wr_field)
                    FLD_TAG:  ents[e].tag  <= wr_data;
                    FLD_MASK: ents[e].mask <= wr_data;
                    FLD_BASE: ents[e].base <= wr_data;
                    FLD_CTRL: begin
                        ents[e].sup_ok <= wr_data[0];
                        ents[e].usr_ok <= wr_data[1];
                        ents[e].prot   <= wr_data[PROT_W+1:2];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/bat_qualify.sv
// Per-entry qualification: privilege valid bit, masked tag compare and
// a writable protection code. Purely combinational.
module bat_qualify
    import bat_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  bat_entry_t [N_ENT-1:0]  ents,
    input  logic [ADDR_W-1:0]       ea,
    input  logic                    user,
    output logic [N_ENT-1:0]        ok
);
    for (genvar e = 0; e < N_ENT; e++) begin : g_q
        logic priv_ok, addr_ok, prot_ok;
        // Decide whether entry e is a usable translation for this request
        always_comb begin
            priv_ok = user ? ents[e].usr_ok : ents[e].sup_ok;
            addr_ok = ((ea & ents[e].mask) == ents[e].tag);
            prot_ok = (ents[e].prot >= PROT_W'(PROT_RW_MIN));
            ok[e]   = priv_ok && addr_ok && prot_ok;
        end
    end
endmodule

// File: rtl/bat_pick.sv
// Fixed-priority selector: the lowest set bit of req wins.
// Assumes idx is only meaningful when any is 1.
module bat_pick #(
    parameter int N_ENT = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest qualifying index is written last
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/bat_matcher.sv
// Block address translation matcher: two banks of entries, one for
// instruction fetches and one for data accesses. It does one lookup per
// valid request and registers the result one edge later.
// Assumes SEG_W + 16 fits the virtual page consumer and ADDR_W >= 28.
module bat_matcher
    import bat_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int SEG_W = 24,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int VPG_W = SEG_W + 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_side,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_field,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              req_valid,
    input  logic              req_side,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] req_ea,
    input  logic [SEG_W-1:0]  req_seg,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_miss,
    output logic [ADDR_W-1:0] res_paddr,
    output logic              res_read,
    output logic              res_write,
    output logic              res_exec,
    output logic [VPG_W-1:0]  res_vpage
);
    localparam int N_BANK = 2;

    bat_entry_t [N_ENT-1:0] bank_ents [N_BANK];
    bat_entry_t [N_ENT-1:0] sel_ents;
    logic [N_ENT-1:0]       qual;
    logic                   any_hit;
    logic [IDX_W-1:0]       win_idx;
    bat_entry_t             win;
    bat_field_e             wr_fld;

    assign wr_fld = bat_field_e'(wr_field);

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_en && (wr_side == 1'(b));
        bat_entry_bank #(.N_ENT(N_ENT)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_we),
            .wr_idx   (wr_idx),
            .wr_field (wr_fld),
            .wr_data  (wr_data),
            .ents     (bank_ents[b])
        );
    end

    // Present the bank named by the request to the shared compare logic
    always_comb sel_ents = req_side ? bank_ents[1] : bank_ents[0];

    bat_qualify #(.N_ENT(N_ENT)) u_qual (
        .ents (sel_ents),
        .ea   (req_ea),
        .user (req_user),
        .ok   (qual)
    );

    bat_pick #(.N_ENT(N_ENT)) u_pick (
        .req (qual),
        .any (any_hit),
        .idx (win_idx)
    );

    // Fetch the winning entry for address and permission formation
    always_comb win = sel_ents[win_idx];

    // Register the lookup result; hold it between requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_miss  <= 1'b0;
            res_paddr <= '0;
            res_read  <= 1'b0;
            res_write <= 1'b0;
            res_exec  <= 1'b0;
            res_vpage <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_hit  <= any_hit;
                res_miss <= !any_hit;
                if (any_hit) begin
                    res_paddr <= win.base | (req_ea & ~win.mask);
                    res_read  <= (win.prot != '0);
                    res_write <= (win.prot >= PROT_W'(PROT_RW_MIN));
                    res_exec  <= 1'b1;
                    res_vpage <= {req_seg, req_ea[27:12]};
                end else begin
                    res_paddr <= '0;
                    res_read  <= 1'b0;
                    res_write <= 1'b0;
                    res_exec  <= 1'b0;
                    res_vpage <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/bat_matcher_chk.sv
// Protocol and result checks for bat_matcher, attached through bind.
module bat_matcher_chk #(
    parameter int ADDR_W = 32,
    parameter int VPG_W  = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              res_valid,
    input logic              res_hit,
    input logic              res_miss,
    input logic [ADDR_W-1:0] res_paddr,
    input logic              res_read,
    input logic              res_write,
    input logic              res_exec,
    input logic [VPG_W-1:0]  res_vpage
);
    // R9
    result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    // R9
    no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(res_paddr) && $stable(res_hit) && $stable(res_vpage)));
    // R8
    hit_miss_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit != res_miss));
    // R8
    miss_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_miss) |->
            (res_paddr == '0 && res_vpage == '0 && !res_read && !res_write && !res_exec));
    // R5
    hit_full_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (res_read && res_write && res_exec));
endmodule

bind bat_matcher bat_matcher_chk #(.ADDR_W(bat_pkg::ADDR_W), .VPG_W(VPG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_miss  (res_miss),
    .res_paddr (res_paddr),
    .res_read  (res_read),
    .res_write (res_write),
    .res_exec  (res_exec),
    .res_vpage (res_vpage)
);

// File: tb/bat_matcher_test.sv
module bat_matcher_test;
    localparam int N_VEC = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_side;
    logic [2:0]  wr_idx;
    logic [1:0]  wr_field;
    logic [31:0] wr_data;
    logic        req_valid, req_side, req_user;
    logic [31:0] req_ea;
    logic [23:0] req_seg;
    logic        res_valid, res_hit, res_miss, res_read, res_write, res_exec;
    logic [31:0] res_paddr;
    logic [39:0] res_vpage;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bat_matcher uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side),
        .wr_idx(wr_idx), .wr_field(wr_field), .wr_data(wr_data),
        .req_valid(req_valid), .req_side(req_side), .req_user(req_user),
        .req_ea(req_ea), .req_seg(req_seg), .res_valid(res_valid),
        .res_hit(res_hit), .res_miss(res_miss), .res_paddr(res_paddr),
        .res_read(res_read), .res_write(res_write), .res_exec(res_exec),
        .res_vpage(res_vpage)
    );

    // vector table: bank (1 = data), user flag, address, expected hit, expected physical
    localparam logic        V_SIDE [N_VEC] = '{1, 1, 1, 1, 1, 0, 0, 1, 1, 1};
    localparam logic        V_USER [N_VEC] = '{0, 1, 0, 1, 0, 0, 1, 0, 0, 1};
    localparam logic [31:0] V_EA   [N_VEC] = '{32'h1234_5678, 32'h1234_5678, 32'h2001_2345,
                                               32'h2001_2345, 32'h3000_0100, 32'h2001_2345,
                                               32'h2001_2345, 32'h2002_0000, 32'h1000_1234,
                                               32'h4000_0000};
    localparam logic        V_HIT  [N_VEC] = '{1, 1, 1, 1, 0, 1, 0, 0, 1, 0};
    localparam logic [31:0] V_PA   [N_VEC] = '{32'h8234_5678, 32'h9234_5678, 32'h0061_2345,
                                               32'h0061_2345, 32'h0, 32'h0071_2345,
                                               32'h0, 32'h0, 32'h8000_1234, 32'h0};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic side, input logic [2:0] idx, input logic [1:0] fld,
                      input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_side = side; wr_idx = idx; wr_field = fld; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic side, input logic [2:0] idx, input logic [31:0] tag,
                        input logic [31:0] mask, input logic [31:0] base, input logic [3:0] ctrl);
        wr(side, idx, 2'd0, tag);
        wr(side, idx, 2'd1, mask);
        wr(side, idx, 2'd2, base);
        wr(side, idx, 2'd3, {28'd0, ctrl});
    endtask

    task automatic lookup(input logic side, input logic user, input logic [31:0] ea,
                          input logic [23:0] seg);
        @(negedge clk);
        req_valid = 1'b1; req_side = side; req_user = user; req_ea = ea; req_seg = seg;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic hit, input logic [31:0] pa,
                              input logic [31:0] ea, input logic [23:0] seg);
        logic [39:0] vp;
        vp = hit ? {seg, ea[27:12]} : 40'd0;
        check({req, " valid"}, 64'(res_valid), 64'(1));
        check({req, " hit"},   64'({res_hit, res_miss}), 64'({hit, !hit}));
        check({req, " paddr"}, 64'(res_paddr), 64'(pa));
        check({req, " perms"}, 64'({res_read, res_write, res_exec}), hit ? 64'(7) : 64'(0));
        check({req, " vpage R7"}, 64'(res_vpage), 64'(vp));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_side = 1'b0; wr_idx = '0; wr_field = '0; wr_data = '0;
        req_valid = 1'b0; req_side = 1'b0; req_user = 1'b0; req_ea = '0; req_seg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state of outputs
        check("R11 outputs after reset", 64'({res_valid, res_hit, res_miss, res_paddr}), 64'(0));

        // R10 entries loaded through the write port; ctrl = {prot, usr, sup}
        load(1, 0, 32'h1000_0000, 32'hF000_0000, 32'h8000_0000, 4'b10_01);
        load(1, 1, 32'h1000_0000, 32'hF000_0000, 32'h9000_0000, 4'b11_10);
        load(1, 2, 32'h2000_0000, 32'hFFFE_0000, 32'h0040_0000, 4'b01_11);
        load(1, 3, 32'h2000_0000, 32'hFFFE_0000, 32'h0060_0000, 4'b10_11);
        load(1, 4, 32'h3000_0000, 32'hFFFE_0000, 32'h0010_0000, 4'b00_01);
        load(1, 5, 32'h1000_0000, 32'hFFFE_0000, 32'h00A0_0000, 4'b10_01);
        load(0, 0, 32'h2000_0000, 32'hFFFE_0000, 32'h0070_0000, 4'b10_01);

        // R1 R2 R3 R4 R5 R6 R8 table of lookups
        for (int v = 0; v < N_VEC; v++) begin
            lookup(V_SIDE[v], V_USER[v], V_EA[v], 24'hABCDEF);
            expect_res($sformatf("R1/R2/R3/R4/R5/R6/R8 vector %0d", v),
                       V_HIT[v], V_PA[v], V_EA[v], 24'hABCDEF);
        end

        // R9 no request: strobe low, previous result held
        lookup(1, 0, 32'h1234_5678, 24'h000123);
        @(negedge clk);
        check("R9 idle strobe", 64'(res_valid), 64'(0));
        check("R9 idle hold", 64'(res_paddr), 64'(32'h8234_5678));

        // R10 rewrite no-access entry to read/write, seen on next lookup
        wr(1, 4, 2'd3, 32'h0000_000D);
        lookup(1, 0, 32'h3000_0100, 24'h000001);
        expect_res("R10 rewritten control", 1'b1, 32'h0010_0100, 32'h3000_0100, 24'h000001);

        // R1 data-bank write left the instruction bank untouched
        lookup(0, 0, 32'h3000_0100, 24'h000001);
        expect_res("R1 bank isolation", 1'b0, 32'h0, 32'h3000_0100, 24'h000001);

        // R11 reset clears entries
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R11 outputs cleared", 64'({res_valid, res_hit, res_paddr}), 64'(0));
        lookup(1, 0, 32'h1234_5678, 24'h000001);
        expect_res("R11 entries cleared", 1'b0, 32'h0, 32'h1234_5678, 24'h000001);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule